// File: doc/BRIEF.md
# Indirect Byte Register Access Bridge

This block gives a 32-bit host register port access to an internal space of up to 256 byte-wide registers. The host writes a single packed command word. That word holds an 8-bit register address, a byte of write data and a direction flag. The bridge then drives one access on an internal byte-bus master interface.

While the access is in flight, a busy bit in the same word reads as 1. A read access captures the byte returned by the internal bus. The host then finds that byte in the top byte of the word once busy has cleared.

Every access lasts a fixed number of core clock cycles, set by a parameter. Commands that arrive during that window are dropped, and the access in flight is not disturbed. The host therefore polls busy before it issues the next command.

Top module: `byte_reg_bridge`

## Requirements
- R1: In a command word, bits 7:0 carry the internal register address and bits 15:8 carry the write byte. These appear on `bus_addr_o` and `bus_wdata_o` for the whole access.
- R2: Command bit 16 selects the direction: 1 is a write, 0 is a read. `bus_we_o` equals that bit during the access. A write leaves the read-data byte of the status word unchanged.
- R3: Status bit 23 (busy) rises in the cycle after an accepted command write. It stays high for exactly `ACCESS_CYCLES` cycles, then falls.
- R4: For a read, bits 31:24 of the status word hold the value of `bus_rdata_i` in the last access cycle. That value is visible from the first cycle in which busy is low.
- R5: A command written while busy is high is ignored. The address, data and direction of the access in flight stay stable, the busy window is not extended, and no extra access takes place.
- R6: Status bits 22:17 always read as 0. Bits 16:0 return the fields of the last accepted command.
- R7: The captured read byte is held while the bridge is idle and across write accesses. Only a completed read replaces it.
- R8: `bus_req_o` is high exactly while busy is high. After reset the whole status word reads as 0 and no access is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe for the command word |
| host_wdata_i | input | 32 | Command word written by the host |
| host_rdata_o | output | 32 | Status word: read byte, busy, last command |
| bus_req_o | output | 1 | Internal access in progress |
| bus_we_o | output | 1 | Internal access is a write |
| bus_addr_o | output | 8 | Internal register address |
| bus_wdata_o | output | 8 | Internal write byte |
| bus_rdata_i | input | 8 | Internal read byte |

## Verification
The hardest case to reach from the ports is a second command that lands while an access is still in flight. A well-behaved host never does this, because it waits for busy to clear. The bench deliberately drives a foreign command, with a different address, data and direction, in the middle of a random subset of accesses. It then checks three things: the bus fields held steady, the busy window kept its exact length, and the register the foreign command targeted was left untouched when read back later. A register model attached to the byte bus gives the expected read values, and a write-then-read sequence confirms that writes landed.

// File: rtl/byte_reg_bridge_pkg.sv
package byte_reg_bridge_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int WORD_W = 32;
  localparam int WE_BIT = 16;
  localparam int BUSY_BIT = 23;

  typedef struct packed {
    logic              we;
    logic [DATA_W-1:0] wdata;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import byte_reg_bridge_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output cmd_t              cmd_o
);
  assign cmd_o.addr  = word_i[ADDR_W-1:0];
  assign cmd_o.wdata = word_i[ADDR_W+DATA_W-1:ADDR_W];
  assign cmd_o.we    = word_i[WE_BIT];
endmodule

// File: rtl/access_timer.sv
module access_timer #(
  parameter int ACCESS_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);
  localparam int CNT_W = (ACCESS_CYCLES > 1) ? $clog2(ACCESS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(ACCESS_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_INIT;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);

  // R3
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o);
  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q <= CNT_INIT);
endmodule

// File: rtl/byte_reg_bridge.sv
module byte_reg_bridge
  import byte_reg_bridge_pkg::*;
#(
  parameter int ACCESS_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int PAD_W = BUSY_BIT - WE_BIT - 1;

  cmd_t              dec_cmd;
  cmd_t              cmd_q;
  logic              busy;
  logic              last;
  logic              accept;
  logic [DATA_W-1:0] rd_q;

  cmd_decode u_dec (
    .word_i (host_wdata_i),
    .cmd_o  (dec_cmd)
  );

  assign accept = host_wr_i && !busy;

  access_timer #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .busy_o  (busy),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q <= dec_cmd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (last && !cmd_q.we) begin
      rd_q <= bus_rdata_i;
    end
  end

  assign bus_req_o   = busy;
  assign bus_we_o    = busy && cmd_q.we;
  assign bus_addr_o  = cmd_q.addr;
  assign bus_wdata_o = cmd_q.wdata;

  assign host_rdata_o = {rd_q, busy, {PAD_W{1'b0}}, cmd_q.we, cmd_q.wdata, cmd_q.addr};

  // R5
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && $past(bus_req_o) |-> $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o));
  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |=> $stable(rd_q));
  // R4
  rd_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) && !cmd_q.we |-> rd_q == $past(bus_rdata_i));
  // R2
  wr_keeps_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |=> $stable(rd_q));
endmodule

// File: tb/byte_reg_bridge_bench.sv
module byte_reg_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        bus_req, bus_we;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [7:0]  exp_rd;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_reg_bridge #(.ACCESS_CYCLES(N)) u_byte_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (bus_req && bus_we) begin
      mem[bus_addr] <= bus_wdata;
    end
  end
  assign bus_rdata = mem[bus_addr];

  function automatic logic [31:0] mk_cmd(logic [7:0] a, logic [7:0] d, logic we);
    return {8'h00, 7'h00, we, d, a};
  endfunction

  function automatic logic [31:0] exp_status(logic [7:0] rd, logic busy, logic [31:0] cmd);
    return {rd, busy, 6'b0, cmd[16:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one command; optionally inject a foreign command mid-access.
  task automatic issue(logic [31:0] cmd, bit inject, logic [31:0] foreign);
    int n;
    @(negedge clk);
    host_wr = 1'b1; host_wdata = cmd;
    @(negedge clk);
    host_wr = 1'b0;
    n = 0;
    while (bus_req && n < 100) begin
      chk("R8 req while busy", 32'(host_rdata[23]), 32'd1);
      chk("R1 addr", 32'(bus_addr), 32'(cmd[7:0]));
      chk("R1 wdata", 32'(bus_wdata), 32'(cmd[15:8]));
      chk("R2 we", 32'(bus_we), 32'(cmd[16]));
      if (inject && n == 1) begin host_wr = 1'b1; host_wdata = foreign; end
      else host_wr = 1'b0;
      n++;
      @(negedge clk);
    end
    host_wr = 1'b0;
    chk("R3 busy length", 32'(n), 32'(N));
    if (cmd[16]) exp_mem[cmd[7:0]] = cmd[15:8];
    else exp_rd = exp_mem[cmd[7:0]];
    chk("R4 R6 R7 status after access", host_rdata, exp_status(exp_rd, 1'b0, cmd));
    chk("R5 R8 no extra access", 32'(bus_req), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    exp_rd = 8'h00;
    repeat (3) @(negedge clk);
    chk("R8 reset status", host_rdata, 32'h0);
    chk("R8 reset req", 32'(bus_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed: read, write, read back, boundary addresses
    issue(mk_cmd(8'h00, 8'hFF, 1'b0), 0, '0);
    issue(mk_cmd(8'hFF, 8'hC3, 1'b1), 0, '0);   // R2 write keeps rd byte
    issue(mk_cmd(8'hFF, 8'h00, 1'b0), 0, '0);
    // R6 reserved bits driven: host writes ones into 31:17, still zero back
    issue(32'hFFFE_A511 & 32'hFFFE_FFFF, 0, '0);
    chk("R6 reserved bits", 32'(host_rdata[22:17]), 32'd0);
    // R5 foreign write during a read must not land
    issue(mk_cmd(8'h10, 8'h00, 1'b0), 1, mk_cmd(8'h20, 8'hEE, 1'b1));
    issue(mk_cmd(8'h20, 8'h00, 1'b0), 0, '0);
    chk("R5 foreign write ignored", 32'(host_rdata[31:24]), 32'(init_val(8'h20)));
    // R7 idle hold
    repeat (5) @(negedge clk);
    chk("R7 idle hold", 32'(host_rdata[31:24]), 32'(init_val(8'h20)));
    // Random
    void'($urandom(32'd1234));
    for (int k = 0; k < 60; k++) begin
      logic [7:0] a, d, fa, fd;
      logic we, fwe;
      bit inj;
      a = 8'($urandom_range(0, 15)); d = 8'($urandom);
      we = 1'($urandom); inj = ($urandom_range(0, 3) == 0);
      fa = a ^ 8'h01; fd = 8'($urandom); fwe = 1'($urandom);
      issue(mk_cmd(a, d, we), inj, mk_cmd(fa, fd, fwe));
      if (($urandom_range(0, 4)) == 0) repeat ($urandom_range(1, 4)) @(negedge clk);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule